// File: doc/BRIEF.md
# Mixed-Access Control/Status Register Slave

This block is a small register file on an APB slave port. It holds the control settings of a peripheral, shows the peripheral's live hardware state, latches a completion event and issues a start command. Within each word, every field has its own access rule. Control fields are read-write. Status fields are driven by hardware and are read-only. The completion flag is set by hardware and cleared when software writes a one to it. The command bit is write-only and fires a pulse.

Writes to the control word are merged byte lane by byte lane under the strobes, so software can rewrite one lane and leave the others alone. Two alias words, one that sets control bits and one that clears them, let software change a single control bit in one write, with no read-modify-write. The slave never inserts wait states. It flags writes that reach read-only or unmapped locations with an error response.

Top module: `mixacc_csr`

## Requirements
- R1: While presetn is low, and after reset, every field reads its reset value: enable, mode, threshold and the done flag are 0, and start_pulse is 0. Reset takes effect at once. Its release reaches the registers two pclk edges after presetn rises.
- R2: CTRL at offset 0x00 stores enable at bit 0, mode at bits 3:1 and threshold at bits 31:16, and reads them back. Bits 15:4 always read 0. The stored fields drive ctrl_en, ctrl_mode and ctrl_thresh.
- R3: A CTRL write changes only the byte lanes whose pstrb bit is 1 (pstrb bit i covers data bits 8i+7:8i). A write with strobe 0010 leaves enable, mode and threshold unchanged.
- R4: STATUS at offset 0x04 reads hw_busy at bit 0 and hw_code at bits 7:4, with all other bits 0. A write to STATUS changes no state and returns pslverr = 1.
- R5: IFLAG at offset 0x08 bit 0 is set by hw_done. A write with bit 0 = 1 under strobe lane 0 clears it. A write with bit 0 = 0 leaves it set.
- R6: If hw_done is high in the same cycle as a clearing write, the done flag stays 1.
- R7: A write to CMD at offset 0x0C with bit 0 = 1 under strobe lane 0 drives start_pulse high for exactly one pclk cycle, the cycle after the access edge. Writing 0 gives no pulse. Reads of CMD return 0.
- R8: A write to the set alias at offset 0x14-0x04 = 0x10 sets every CTRL field bit that carries a 1 in a strobed lane. Zero bits have no effect. The alias reads 0.
- R9: A write to the clear alias at offset 0x14 clears every CTRL field bit that carries a 1 in a strobed lane. Zero bits have no effect. The alias reads 0.
- R10: Reads of unmapped or unaligned offsets return 0. Writes to them change no state and return pslverr = 1. pslverr is 0 for every read and for writes to writable offsets. pready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte lane write strobes |
| prdata | output | 32 | Read data, valid while a read is selected |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Error for writes to read-only or unmapped offsets |
| hw_busy | input | 1 | Hardware busy status |
| hw_code | input | 4 | Hardware status code |
| hw_done | input | FLAG_N (1) | Completion event that sets the done flag |
| ctrl_en | output | 1 | Enable field |
| ctrl_mode | output | 3 | Mode field |
| ctrl_thresh | output | 16 | Threshold field |
| start_pulse | output | 1 | One-cycle start command |

## Verification
prdata and pslverr are combinational from the bus inputs, so the bench samples them on the falling edge inside the access phase. A register write lands on the rising edge that ends the access phase. Its effect on the field outputs and on start_pulse is therefore due in the next cycle, and the bench samples it on the falling edge at which the write task returns. The start pulse must be gone one cycle later. A hw_done pulse is captured on one rising edge and is checked by a later read. After presetn rises, the bench waits for the two-stage reset release before its first access, and it checks the outputs during reset a nanosecond after presetn falls.

// File: rtl/mixacc_csr_pkg.sv
package mixacc_csr_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;

  // byte offsets of the map
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_STAT = 'h04;
  localparam int unsigned OFS_FLAG = 'h08;
  localparam int unsigned OFS_CMD  = 'h0C;
  localparam int unsigned OFS_SET  = 'h10;
  localparam int unsigned OFS_CLR  = 'h14;

  // only these CTRL bits hold storage: thresh[31:16], mode[3:1], en[0]
  localparam logic [DATA_W-1:0] CTRL_FIELD_MASK = 32'hFFFF_000F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_FLAG,
    SEL_CMD,
    SEL_SET,
    SEL_CLR
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] lane_expand(input logic [STRB_W-1:0] s);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < STRB_W; i++) m[8*i +: 8] = {8{s[i]}};
    return m;
  endfunction

endpackage

// File: rtl/mixacc_rst_sync.sv
module mixacc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mixacc_apb_decode.sv
module mixacc_apb_decode
  import mixacc_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel,
  output logic              acc_wr,
  output logic              rd_sel,
  output logic              slverr
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if      (word_idx == IDX_W'(OFS_CTRL >> 2)) sel = SEL_CTRL;
      else if (word_idx == IDX_W'(OFS_STAT >> 2)) sel = SEL_STAT;
      else if (word_idx == IDX_W'(OFS_FLAG >> 2)) sel = SEL_FLAG;
      else if (word_idx == IDX_W'(OFS_CMD  >> 2)) sel = SEL_CMD;
      else if (word_idx == IDX_W'(OFS_SET  >> 2)) sel = SEL_SET;
      else if (word_idx == IDX_W'(OFS_CLR  >> 2)) sel = SEL_CLR;
    end
  end

  assign acc_wr = psel & penable & pwrite;
  assign rd_sel = psel & ~pwrite;
  assign slverr = acc_wr & ((sel == SEL_STAT) | (sel == SEL_NONE));
endmodule

// File: rtl/mixacc_ctrl_reg.sv
module mixacc_ctrl_reg
  import mixacc_csr_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIELD_MASK = CTRL_FIELD_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] strb,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] lane_m;
  logic [DATA_W-1:0] d;
  logic              upd;

  assign lane_m = lane_expand(strb);
  assign upd    = wr_en | set_en | clr_en;

  // next-state: lane merge, set alias, clear alias
  always_comb begin
    d = q;
    if (wr_en)       d = (q & ~lane_m) | (wdata & lane_m);
    else if (set_en) d = q | (wdata & lane_m);
    else if (clr_en) d = q & ~(wdata & lane_m);
    d = d & FIELD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/mixacc_event_flags.sv
module mixacc_event_flags #(
  parameter int unsigned FLAG_N = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] evt,
  input  logic [FLAG_N-1:0] clr,
  output logic [FLAG_N-1:0] q
);
  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    logic d_bit;
    logic upd_bit;

    // an event in the clearing cycle wins so it is never lost
    always_comb begin
      upd_bit = evt[g] | clr[g];
      d_bit   = evt[g] | (q[g] & ~clr[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[g] <= 1'b0;
      else if (upd_bit) q[g] <= d_bit;
    end
  end
endmodule

// File: rtl/mixacc_cmd_pulse.sv
module mixacc_cmd_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_d;

  always_comb pulse_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= pulse_d;
  end
endmodule

// File: rtl/mixacc_csr.sv
module mixacc_csr
  import mixacc_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned FLAG_N = 1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              hw_busy,
  input  logic [3:0]        hw_code,
  input  logic [FLAG_N-1:0] hw_done,
  output logic              ctrl_en,
  output logic [2:0]        ctrl_mode,
  output logic [15:0]       ctrl_thresh,
  output logic              start_pulse
);
  logic              rst_q_n;
  reg_sel_e          sel;
  logic              acc_wr;
  logic              rd_sel;
  logic [DATA_W-1:0] ctrl_q;
  logic [FLAG_N-1:0] flag_q;
  logic [FLAG_N-1:0] flag_clr;
  logic [DATA_W-1:0] lane_m;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_word;
  logic              cmd_fire;

  mixacc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_q_n)
  );

  mixacc_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .sel     (sel),
    .acc_wr  (acc_wr),
    .rd_sel  (rd_sel),
    .slverr  (pslverr)
  );

  mixacc_ctrl_reg #(.FIELD_MASK(CTRL_FIELD_MASK)) u_ctrl (
    .clk    (pclk),
    .rst_n  (rst_q_n),
    .wr_en  (acc_wr & (sel == SEL_CTRL)),
    .set_en (acc_wr & (sel == SEL_SET)),
    .clr_en (acc_wr & (sel == SEL_CLR)),
    .wdata  (pwdata),
    .strb   (pstrb),
    .q      (ctrl_q)
  );

  assign lane_m   = lane_expand(pstrb);
  assign flag_clr = {FLAG_N{acc_wr & (sel == SEL_FLAG)}} & pwdata[FLAG_N-1:0] & lane_m[FLAG_N-1:0];

  mixacc_event_flags #(.FLAG_N(FLAG_N)) u_flags (
    .clk   (pclk),
    .rst_n (rst_q_n),
    .evt   (hw_done),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  assign cmd_fire = acc_wr & (sel == SEL_CMD) & pstrb[0] & pwdata[0];

  mixacc_cmd_pulse u_cmd (
    .clk   (pclk),
    .rst_n (rst_q_n),
    .fire  (cmd_fire),
    .pulse (start_pulse)
  );

  always_comb begin
    stat_word      = '0;
    stat_word[0]   = hw_busy;
    stat_word[7:4] = hw_code;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_word = ctrl_q;
      SEL_STAT: rd_word = stat_word;
      SEL_FLAG: rd_word = DATA_W'(flag_q);
      default:  rd_word = '0;
    endcase
  end

  assign prdata      = rd_sel ? rd_word : '0;
  assign pready      = 1'b1;
  assign ctrl_en     = ctrl_q[0];
  assign ctrl_mode   = ctrl_q[3:1];
  assign ctrl_thresh = ctrl_q[31:16];
endmodule

// File: rtl/mixacc_csr_chk.sv
module mixacc_csr_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [3:0]        pstrb,
  input logic [31:0]       prdata,
  input logic              pslverr,
  input logic              hw_done,
  input logic              done_flag,
  input logic              ctrl_en,
  input logic [2:0]        ctrl_mode,
  input logic [15:0]       ctrl_thresh,
  input logic              start_pulse
);
  logic wr_acc, rd_acc, ctrl_wr, flag_clr_wr, cmd_fire;

  assign wr_acc      = psel & penable & pwrite;
  assign rd_acc      = psel & penable & ~pwrite;
  assign ctrl_wr     = wr_acc & (paddr == ADDR_W'(8'h00));
  assign flag_clr_wr = wr_acc & (paddr == ADDR_W'(8'h08)) & pstrb[0] & pwdata[0];
  assign cmd_fire    = wr_acc & (paddr == ADDR_W'(8'h0C)) & pstrb[0] & pwdata[0];

  assert_lane0_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !pstrb[0]) |=> ($stable(ctrl_en) && $stable(ctrl_mode)));

  assert_upper_lanes_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && pstrb[3:2] == 2'b00) |=> $stable(ctrl_thresh));

  assert_status_write_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == ADDR_W'(8'h04)) |-> pslverr);

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr_wr) |=> done_flag);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> done_flag);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> $past(cmd_fire));

  assert_set_alias_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && paddr == ADDR_W'(8'h10)) |-> (prdata == 32'h0));

  assert_clr_alias_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && paddr == ADDR_W'(8'h14)) |-> (prdata == 32'h0));

  assert_read_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> !pslverr);
endmodule

bind mixacc_csr mixacc_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (pclk),
  .rst_n       (rst_q_n),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .pstrb       (pstrb),
  .prdata      (prdata),
  .pslverr     (pslverr),
  .hw_done     (hw_done[0]),
  .done_flag   (flag_q[0]),
  .ctrl_en     (ctrl_en),
  .ctrl_mode   (ctrl_mode),
  .ctrl_thresh (ctrl_thresh),
  .start_pulse (start_pulse)
);

// File: tb/mixacc_csr_bench.sv
module mixacc_csr_bench;
  logic        clk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [3:0]  pstrb;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        hw_busy;
  logic [3:0]  hw_code;
  logic [0:0]  hw_done;
  logic        ctrl_en;
  logic [2:0]  ctrl_mode;
  logic [15:0] ctrl_thresh;
  logic        start_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mixacc_csr u_mixacc_csr (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .hw_busy(hw_busy), .hw_code(hw_code), .hw_done(hw_done),
    .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .ctrl_thresh(ctrl_thresh),
    .start_pulse(start_pulse)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        input bit done_too, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1'b1;
    if (done_too) hw_done = 1'b1;
    #1 err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; hw_done = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; pstrb = 4'h0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); hw_done = 1'b1;
    @(negedge clk); hw_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R1", "ctrl_en at reset", 32'(ctrl_en), 32'h0);
    check("R1", "ctrl_mode at reset", 32'(ctrl_mode), 32'h0);
    check("R1", "ctrl_thresh at reset", 32'(ctrl_thresh), 32'h0);
    check("R1", "start_pulse at reset", 32'(start_pulse), 32'h0);
    check("R10", "pready", 32'(pready), 32'h1);
    apb_rd(8'h00, d, e); check("R1", "CTRL read after reset", d, 32'h0);
    apb_rd(8'h08, d, e); check("R1", "IFLAG read after reset", d, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d; logic e;
    apb_wr(8'h00, 32'hABCD_FFFF, 4'hF, 0, e);
    check("R10", "pslverr on CTRL write", 32'(e), 32'h0);
    check("R2", "ctrl_en", 32'(ctrl_en), 32'h1);
    check("R2", "ctrl_mode", 32'(ctrl_mode), 32'h7);
    check("R2", "ctrl_thresh", 32'(ctrl_thresh), 32'hABCD);
    apb_rd(8'h00, d, e); check("R2", "CTRL readback, reserved bits 0", d, 32'hABCD_000F);
  endtask

  task automatic t_strobe();
    logic [31:0] d; logic e;
    apb_wr(8'h00, 32'h0000_0000, 4'b0010, 0, e);
    apb_rd(8'h00, d, e); check("R3", "strobe 0010 leaves CTRL", d, 32'hABCD_000F);
    apb_wr(8'h00, 32'h1234_0002, 4'b0001, 0, e);
    check("R3", "lane0 write: thresh kept", 32'(ctrl_thresh), 32'hABCD);
    check("R3", "lane0 write: mode", 32'(ctrl_mode), 32'h1);
    check("R3", "lane0 write: en", 32'(ctrl_en), 32'h0);
    apb_wr(8'h00, 32'h5600_00FF, 4'b1000, 0, e);
    apb_rd(8'h00, d, e); check("R3", "lane3 write only top byte", d, 32'h56CD_0002);
  endtask

  task automatic t_status();
    logic [31:0] d; logic e;
    hw_busy = 1'b1; hw_code = 4'hA;
    apb_rd(8'h04, d, e); check("R4", "STATUS layout", d, 32'h0000_00A1);
    apb_wr(8'h04, 32'hFFFF_FFFF, 4'hF, 0, e);
    check("R4", "pslverr on STATUS write", 32'(e), 32'h1);
    apb_rd(8'h04, d, e); check("R4", "STATUS after write", d, 32'h0000_00A1);
    apb_rd(8'h00, d, e); check("R4", "CTRL untouched by STATUS write", d, 32'h56CD_0002);
    hw_busy = 1'b0; hw_code = 4'h3;
    apb_rd(8'h04, d, e); check("R4", "STATUS follows hw", d, 32'h0000_0030);
  endtask

  task automatic t_iflag();
    logic [31:0] d; logic e;
    pulse_done();
    apb_rd(8'h08, d, e); check("R5", "done flag set", d, 32'h1);
    apb_wr(8'h08, 32'h0, 4'hF, 0, e);
    check("R10", "pslverr on IFLAG write", 32'(e), 32'h0);
    apb_rd(8'h08, d, e); check("R5", "write 0 keeps flag", d, 32'h1);
    apb_wr(8'h08, 32'h1, 4'b1110, 0, e);
    apb_rd(8'h08, d, e); check("R5", "unstrobed lane0 keeps flag", d, 32'h1);
    apb_wr(8'h08, 32'h1, 4'hF, 0, e);
    apb_rd(8'h08, d, e); check("R5", "write 1 clears flag", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d; logic e;
    pulse_done();
    apb_wr(8'h08, 32'h1, 4'hF, 1, e);
    apb_rd(8'h08, d, e); check("R6", "event during clear kept", d, 32'h1);
    apb_wr(8'h08, 32'h1, 4'hF, 0, e);
    apb_rd(8'h08, d, e); check("R6", "later clear works", d, 32'h0);
  endtask

  task automatic t_cmd();
    logic [31:0] d; logic e;
    check("R7", "no pulse before command", 32'(start_pulse), 32'h0);
    apb_wr(8'h0C, 32'h1, 4'hF, 0, e);
    check("R7", "start pulse in cycle after access", 32'(start_pulse), 32'h1);
    @(negedge clk);
    check("R7", "start pulse one cycle only", 32'(start_pulse), 32'h0);
    apb_wr(8'h0C, 32'h0, 4'hF, 0, e);
    check("R7", "writing 0 gives no pulse", 32'(start_pulse), 32'h0);
    apb_rd(8'h0C, d, e); check("R7", "CMD reads 0", d, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] d; logic e;
    apb_wr(8'h10, 32'h0002_0001, 4'hF, 0, e);
    apb_rd(8'h00, d, e); check("R8", "set alias result", d, 32'h56CF_0003);
    apb_rd(8'h10, d, e); check("R8", "set alias reads 0", d, 32'h0);
    apb_wr(8'h14, 32'h5600_0002, 4'hF, 0, e);
    apb_rd(8'h00, d, e); check("R9", "clear alias result", d, 32'h00CF_0001);
    apb_rd(8'h14, d, e); check("R9", "clear alias reads 0", d, 32'h0);
    apb_wr(8'h14, 32'h00FF_0000, 4'b1000, 0, e);
    check("R9", "clear alias respects strobes", 32'(ctrl_thresh), 32'h00CF);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    apb_rd(8'h18, d, e);
    check("R10", "unmapped read data", d, 32'h0);
    check("R10", "pslverr on read", 32'(e), 32'h0);
    apb_rd(8'h02, d, e); check("R10", "unaligned read data", d, 32'h0);
    apb_wr(8'h1C, 32'hFFFF_FFFF, 4'hF, 0, e);
    check("R10", "pslverr on unmapped write", 32'(e), 32'h1);
    apb_wr(8'h01, 32'hFFFF_FFFF, 4'hF, 0, e);
    apb_rd(8'h00, d, e); check("R10", "CTRL untouched by stray writes", d, 32'h00CF_0001);
  endtask

  task automatic t_async_reset();
    logic [31:0] d; logic e;
    @(negedge clk); #1 presetn = 1'b0;
    #1;
    check("R1", "async reset clears en", 32'(ctrl_en), 32'h0);
    check("R1", "async reset clears thresh", 32'(ctrl_thresh), 32'h0);
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    repeat (3) @(negedge clk);
    apb_rd(8'h00, d, e); check("R1", "CTRL after second reset", d, 32'h0);
  endtask

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pstrb = '0;
    hw_busy = 1'b0; hw_code = '0; hw_done = '0;
    repeat (4) @(negedge clk);
    t_reset();
    presetn = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_strobe();
    t_status();
    t_iflag();
    t_race();
    t_cmd();
    t_alias();
    t_unmapped();
    t_async_reset();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule